// File: doc/BRIEF.md
# Descriptor-Chain Transmit DMA Channel

This block is a single transmit DMA channel. Software builds a linked list of buffer descriptors in a small word-addressed descriptor memory and starts the channel by writing the byte address of the first descriptor into a head register. The engine reads each descriptor and streams the buffer it points to as 32-bit beats on a valid/ready output. It then writes completion status back into the descriptor and either follows the next pointer or stops at the end of the queue.

Ownership is a handshake through the mode word. The engine works only on descriptors that software has handed over, and hands each one back once its buffer has gone out. Software acknowledges finished descriptors through a completion-pointer register, which drives a level interrupt. A teardown request stops the channel cleanly at a descriptor boundary and leaves a marker value in the completion pointer.

Top module: `txdma_chain_top`

## Requirements
- R1: After reset the channel is idle: no memory access, `tx_valid_o` and `irq_o` low, and every register reads zero.
- R2: A descriptor at byte address A occupies memory words A/4 to A/4+3, holding in turn the next pointer, the buffer byte address, the buffer length in bytes (low 16 bits) and the mode word. Byte address 0 is null. The engine works on a descriptor only if mode bit 29 (owner) is set. If that bit is clear, the engine stops with no beats and no writeback.
- R3: When a descriptor is finished, its mode word is rewritten with bit 29 cleared. Bit 28 (end of queue) is set exactly when the next pointer is zero, and bit 27 (teardown done) is set when a teardown took effect on it. All other bits are kept.
- R4: A descriptor with length L sends ceil(L/4) beats taken from consecutive memory words starting at its buffer address. A beat holds its data while `tx_ready_i` is low, and L = 0 sends no beat.
- R5: `tx_last_o` is high only on the final beat of a descriptor whose mode bit 30 (end of packet) is set.
- R6: The engine follows a nonzero next pointer and halts after a descriptor with a zero next pointer. A later nonzero head write restarts it from that address.
- R7: Register select 0, bit 0, is the channel enable. While it is 0, no descriptor fetch starts. A head write accepted while disabled stays pending and starts once the enable is set.
- R8: Register select 1 is the head pointer. Writing 0 while idle leaves the channel idle. It reads back the current descriptor address while busy and 0 when idle.
- R9: A head write while the channel is busy (status bit 0) is ignored and sets sticky error status bit 1. Register select 3 reads status {irq at bit 2, error at bit 1, busy at bit 0}.
- R10: Register select 2 is the completion pointer, which software writes. `irq_o`, and status bit 2, are high while it differs from the address of the last descriptor the engine finished.
- R11: Writing the value CHAN_ID to register select 3 requests a teardown, and any other value is ignored. A busy channel stops after its current descriptor and sets bit 27 in it. An idle channel drops any pending start. In both cases the completion pointer loads 0xFFFFFFFC and `irq_o` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select (0 enable, 1 head, 2 completion, 3 teardown/status) |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_sel_i |
| mem_en_o | output | 1 | Descriptor memory access enable |
| mem_we_o | output | 1 | Descriptor memory write enable |
| mem_addr_o | output | MEM_AW | Descriptor memory word address |
| mem_wdata_o | output | 32 | Descriptor memory write data |
| mem_rdata_i | input | 32 | Descriptor memory read data, one cycle after the access |
| tx_data_o | output | 32 | Stream beat data |
| tx_valid_o | output | 1 | Stream beat valid |
| tx_last_o | output | 1 | Final beat of a packet |
| tx_ready_i | input | 1 | Stream sink ready |
| irq_o | output | 1 | Completion interrupt |

## Verification
The streaming path is tried with three patterns: a single descriptor with a free-running sink, a two-descriptor chain under a throttled sink, and a chain held back by a stalled sink. Together these separate beat counting, word order, last-flag placement and hold behaviour under back-pressure. Descriptors with the owner bit clear, with zero length, and started while the enable is off show whether ownership, length and enable gating are honoured. Teardown is issued against both a busy and an idle channel, with a wrong channel value first, to tell a stop at a descriptor boundary apart from an abort or a missed request.

// File: rtl/txdma_pkg.sv
package txdma_pkg;
  localparam int BIT_SOP = 31;
  localparam int BIT_EOP = 30;
  localparam int BIT_OWN = 29;
  localparam int BIT_EOQ = 28;
  localparam int BIT_TDC = 27;
  localparam logic [31:0] TD_MARK = 32'hFFFF_FFFC;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_HEAD = 2'd1;
  localparam logic [1:0] SEL_CP   = 2'd2;
  localparam logic [1:0] SEL_TD   = 2'd3;

  typedef enum logic [3:0] {
    E_IDLE, E_RD_MODE, E_RD_NEXT, E_RD_BUF, E_RD_LEN,
    E_CAP_LEN, E_DAT_RD, E_DAT_CAP, E_DAT_OUT, E_WB
  } eng_state_e;
endpackage

// File: rtl/txdma_regs.sv
module txdma_regs
  import txdma_pkg::*;
#(
  parameter int unsigned CHAN_ID = 0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_wr_i,
  input  logic [1:0]  reg_sel_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  input  logic        eng_busy_i,
  input  logic [31:0] eng_cur_i,
  input  logic        done_i,
  input  logic [31:0] done_addr_i,
  input  logic        td_done_i,
  output logic        en_o,
  output logic        start_o,
  output logic [31:0] start_ptr_o,
  output logic        td_req_o,
  output logic        irq_o
);
  logic        en_q, err_q;
  logic [31:0] cp_q, done_q;
  logic        head_wr, cp_wr;

  assign head_wr     = reg_wr_i && (reg_sel_i == SEL_HEAD);
  assign cp_wr       = reg_wr_i && (reg_sel_i == SEL_CP);
  assign start_o     = head_wr && !eng_busy_i && (reg_wdata_i != '0);
  assign start_ptr_o = reg_wdata_i;
  assign td_req_o    = reg_wr_i && (reg_sel_i == SEL_TD) && (reg_wdata_i == 32'(CHAN_ID));
  assign en_o        = en_q;
  assign irq_o       = (cp_q != done_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      err_q  <= 1'b0;
      cp_q   <= '0;
      done_q <= '0;
    end else begin
      if (reg_wr_i && (reg_sel_i == SEL_CTRL)) en_q <= reg_wdata_i[0];
      if (head_wr && eng_busy_i) err_q <= 1'b1;
      if (td_done_i)  cp_q <= TD_MARK;
      else if (cp_wr) cp_q <= reg_wdata_i;
      if (td_done_i)    done_q <= TD_MARK;
      else if (done_i)  done_q <= done_addr_i;
    end
  end

  always_comb begin
    unique case (reg_sel_i)
      SEL_CTRL: reg_rdata_o = {31'd0, en_q};
      SEL_HEAD: reg_rdata_o = eng_cur_i;
      SEL_CP:   reg_rdata_o = cp_q;
      default:  reg_rdata_o = {29'd0, irq_o, err_q, eng_busy_i};
    endcase
  end

  // R10: a finished descriptor that software has not acknowledged raises the interrupt
  a_r10_irq_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !td_done_i && !cp_wr && (done_addr_i != cp_q)) |=> irq_o);

  // R11: teardown completion leaves the marker and a quiet interrupt
  a_r11_marker_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    td_done_i |=> (reg_sel_i != SEL_CP || reg_rdata_o == TD_MARK || $past(cp_wr)) && !irq_o);
endmodule

// File: rtl/txdma_engine.sv
module txdma_engine
  import txdma_pkg::*;
#(
  parameter int unsigned MEM_AW = 8,
  parameter int unsigned LEN_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              start_i,
  input  logic [31:0]       start_ptr_i,
  input  logic              td_req_i,
  output logic              busy_o,
  output logic [31:0]       cur_o,
  output logic              done_o,
  output logic [31:0]       done_addr_o,
  output logic              td_done_o,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic [31:0]       mem_rdata_i,
  output logic [31:0]       tx_data_o,
  output logic              tx_valid_o,
  output logic              tx_last_o,
  input  logic              tx_ready_i
);
  localparam int unsigned BEAT_W = LEN_W - 1;

  eng_state_e        state_q;
  logic [31:0]       cur_q, mode_q, next_q, dat_q;
  logic              pend_q, td_pend_q, td_now;
  logic [MEM_AW-1:0] wptr_q, cur_word;
  logic [BEAT_W-1:0] left_q, beats;
  logic [LEN_W:0]    len_ext;
  logic [31:0]       wb_mode;

  assign cur_word = cur_q[MEM_AW+1:2];
  assign len_ext  = {1'b0, mem_rdata_i[LEN_W-1:0]} + (LEN_W+1)'(3);
  assign beats    = len_ext[LEN_W:2];
  assign td_now   = td_pend_q | td_req_i;
  assign wb_mode  = {mode_q[BIT_SOP], mode_q[BIT_EOP], 1'b0, (next_q == '0), td_now,
                     mode_q[BIT_TDC-1:0]};

  assign busy_o      = (state_q != E_IDLE) || pend_q;
  assign cur_o       = busy_o ? cur_q : '0;
  assign done_o      = (state_q == E_WB);
  assign done_addr_o = cur_q;
  assign td_done_o   = td_now && ((state_q == E_IDLE) || (state_q == E_WB));
  assign tx_valid_o  = (state_q == E_DAT_OUT);
  assign tx_data_o   = dat_q;
  assign tx_last_o   = tx_valid_o && (left_q == BEAT_W'(1)) && mode_q[BIT_EOP];

  always_comb begin
    mem_en_o    = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = cur_word;
    mem_wdata_o = wb_mode;
    unique case (state_q)
      E_RD_MODE: begin mem_en_o = 1'b1; mem_addr_o = cur_word + MEM_AW'(3); end
      E_RD_NEXT: begin mem_en_o = 1'b1; mem_addr_o = cur_word; end
      E_RD_BUF:  begin mem_en_o = 1'b1; mem_addr_o = cur_word + MEM_AW'(1); end
      E_RD_LEN:  begin mem_en_o = 1'b1; mem_addr_o = cur_word + MEM_AW'(2); end
      E_DAT_RD:  begin mem_en_o = 1'b1; mem_addr_o = wptr_q; end
      E_WB: begin
        mem_en_o   = 1'b1;
        mem_we_o   = 1'b1;
        mem_addr_o = cur_word + MEM_AW'(3);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= E_IDLE;
      cur_q     <= '0;
      mode_q    <= '0;
      next_q    <= '0;
      dat_q     <= '0;
      wptr_q    <= '0;
      left_q    <= '0;
      pend_q    <= 1'b0;
      td_pend_q <= 1'b0;
    end else begin
      td_pend_q <= td_now && !td_done_o;
      unique case (state_q)
        E_IDLE: begin
          if (start_i) begin
            cur_q  <= start_ptr_i;
            pend_q <= 1'b1;
          end
          if (td_now) pend_q <= 1'b0;
          else if (pend_q && en_i) state_q <= E_RD_MODE;
        end
        E_RD_MODE: state_q <= E_RD_NEXT;
        E_RD_NEXT: begin
          mode_q <= mem_rdata_i;
          if (!mem_rdata_i[BIT_OWN]) begin
            pend_q  <= 1'b0;
            state_q <= E_IDLE;
          end else begin
            state_q <= E_RD_BUF;
          end
        end
        E_RD_BUF: begin
          next_q  <= mem_rdata_i;
          state_q <= E_RD_LEN;
        end
        E_RD_LEN: begin
          wptr_q  <= mem_rdata_i[MEM_AW+1:2];
          state_q <= E_CAP_LEN;
        end
        E_CAP_LEN: begin
          left_q  <= beats;
          state_q <= (beats == '0) ? E_WB : E_DAT_RD;
        end
        E_DAT_RD:  state_q <= E_DAT_CAP;
        E_DAT_CAP: begin
          dat_q   <= mem_rdata_i;
          state_q <= E_DAT_OUT;
        end
        E_DAT_OUT: begin
          if (tx_ready_i) begin
            left_q  <= left_q - BEAT_W'(1);
            wptr_q  <= wptr_q + MEM_AW'(1);
            state_q <= (left_q == BEAT_W'(1)) ? E_WB : E_DAT_RD;
          end
        end
        E_WB: begin
          if (td_now || (next_q == '0)) begin
            pend_q  <= 1'b0;
            state_q <= E_IDLE;
          end else begin
            cur_q   <= next_q;
            state_q <= en_i ? E_RD_MODE : E_IDLE;
          end
        end
        default: state_q <= E_IDLE;
      endcase
    end
  end

  // R4: a beat that is not taken stays put
  a_r4_beat_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o) && $stable(tx_last_o)));

  // R5: last only accompanies a valid beat
  a_r5_last_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_last_o |-> tx_valid_o);

  // R3: writeback always returns ownership to software
  a_r3_wb_owner_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> !mem_wdata_o[BIT_OWN]);

  // R2: an idle engine neither touches memory nor streams
  a_r2_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == E_IDLE) |-> (!mem_en_o && !tx_valid_o));

  // R9: a start is only ever offered to an idle engine
  a_r9_start_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> ((state_q == E_IDLE) && !pend_q));
endmodule

// File: rtl/txdma_chain_top.sv
module txdma_chain_top
  import txdma_pkg::*;
#(
  parameter int unsigned MEM_AW  = 8,
  parameter int unsigned LEN_W   = 16,
  parameter int unsigned CHAN_ID = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [1:0]        reg_sel_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic [31:0]       mem_rdata_i,
  output logic [31:0]       tx_data_o,
  output logic              tx_valid_o,
  output logic              tx_last_o,
  input  logic              tx_ready_i,
  output logic              irq_o
);
  logic        en, start, td_req, busy, done, td_done;
  logic [31:0] start_ptr, cur, done_addr;

  txdma_regs #(.CHAN_ID(CHAN_ID)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_wr_i    (reg_wr_i),
    .reg_sel_i   (reg_sel_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .eng_busy_i  (busy),
    .eng_cur_i   (cur),
    .done_i      (done),
    .done_addr_i (done_addr),
    .td_done_i   (td_done),
    .en_o        (en),
    .start_o     (start),
    .start_ptr_o (start_ptr),
    .td_req_o    (td_req),
    .irq_o       (irq_o)
  );

  txdma_engine #(.MEM_AW(MEM_AW), .LEN_W(LEN_W)) u_engine (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en),
    .start_i     (start),
    .start_ptr_i (start_ptr),
    .td_req_i    (td_req),
    .busy_o      (busy),
    .cur_o       (cur),
    .done_o      (done),
    .done_addr_o (done_addr),
    .td_done_o   (td_done),
    .mem_en_o    (mem_en_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_rdata_i (mem_rdata_i),
    .tx_data_o   (tx_data_o),
    .tx_valid_o  (tx_valid_o),
    .tx_last_o   (tx_last_o),
    .tx_ready_i  (tx_ready_i)
  );
endmodule

// File: tb/txdma_chain_top_tb.sv
`timescale 1ns/1ps
module txdma_chain_top_tb;
  localparam int MEM_AW = 8;
  localparam logic [31:0] MARK = 32'hFFFF_FFFC;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mem_en, mem_we;
  logic [MEM_AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [31:0] tx_data;
  logic tx_valid, tx_last, tx_ready;
  logic irq;

  int checks = 0, errors = 0;
  int rdy_mode = 0, cyc = 0, nb = 0;
  logic [31:0] bd [16];
  logic        bl [16];
  logic [31:0] mem [256];

  always #10 clk = ~clk;

  txdma_chain_top #(.MEM_AW(MEM_AW), .LEN_W(16), .CHAN_ID(0)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_sel_i(reg_sel),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .mem_en_o(mem_en),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .tx_data_o(tx_data), .tx_valid_o(tx_valid),
    .tx_last_o(tx_last), .tx_ready_i(tx_ready), .irq_o(irq)
  );

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      mem_rdata <= mem[mem_addr];
    end
  end

  // ready is set for the coming edge, then the beat that edge will take is recorded
  always @(negedge clk) begin
    cyc = cyc + 1;
    case (rdy_mode)
      0: tx_ready = 1'b1;
      1: tx_ready = (cyc % 3) != 0;
      default: tx_ready = 1'b0;
    endcase
    if (rst_n && tx_valid && tx_ready && nb < 16) begin
      bd[nb] = tx_data;
      bl[nb] = tx_last;
      nb = nb + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] sel, output logic [31:0] d);
    @(negedge clk);
    reg_sel = sel;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle(input string tag);
    logic [31:0] s;
    bit done = 0;
    for (int i = 0; i < 400 && !done; i++) begin
      reg_read(2'd3, s);
      if (!s[0]) done = 1;
    end
    chk(done, tag, {31'd0, done}, 32'd1);
  endtask

  task automatic put_desc(input logic [31:0] a, input logic [31:0] nxt, input logic [31:0] bp,
                          input logic [31:0] len, input logic [31:0] mode);
    mem[a[9:2]]     = nxt;
    mem[a[9:2] + 1] = bp;
    mem[a[9:2] + 2] = len;
    mem[a[9:2] + 3] = mode;
  endtask

  task automatic fill_buf(input logic [31:0] bp, input int n, input logic [31:0] seed);
    for (int i = 0; i < n; i++) mem[bp[9:2] + i] = seed + 32'(i);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk(!tx_valid && !irq && !mem_en, "R1 outputs idle", {29'd0, tx_valid, irq, mem_en}, 32'd0);
    for (int s = 0; s < 4; s++) begin
      reg_read(2'(s), v);
      chk(v == 32'd0, "R1 register reads zero", v, 32'd0);
    end
  endtask

  task automatic t_single;
    logic [31:0] v;
    put_desc(32'h40, 32'h0, 32'h200, 32'd10, 32'hE000_000A);
    fill_buf(32'h200, 3, 32'hA000_0000);
    nb = 0; rdy_mode = 0;
    reg_write(2'd0, 32'd1);
    reg_write(2'd1, 32'h40);
    wait_idle("R6 single halts");
    chk(nb == 3, "R4 beat count len 10", 32'(nb), 32'd3);
    for (int i = 0; i < 3; i++)
      chk(bd[i] == 32'hA000_0000 + 32'(i), "R4 beat data", bd[i], 32'hA000_0000 + 32'(i));
    chk(!bl[0] && !bl[1] && bl[2], "R5 last on final beat", {29'd0, bl[0], bl[1], bl[2]}, 32'd1);
    chk(mem[16 + 3] == 32'hD000_000A, "R3 writeback eoq", mem[19], 32'hD000_000A);
    reg_read(2'd3, v);
    chk(irq && v[2], "R10 irq after completion", {31'd0, irq}, 32'd1);
    reg_write(2'd2, 32'h40);
    reg_read(2'd3, v);
    chk(!irq && !v[2], "R10 irq clears on ack", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_chain;
    logic [31:0] v;
    put_desc(32'h80, 32'hA0, 32'h240, 32'd8, 32'hA000_0008);
    put_desc(32'hA0, 32'h0, 32'h280, 32'd4, 32'h6000_0004);
    fill_buf(32'h240, 2, 32'hB000_0000);
    fill_buf(32'h280, 1, 32'hC000_0000);
    nb = 0; rdy_mode = 1;
    reg_write(2'd1, 32'h80);
    reg_write(2'd1, 32'h100);
    reg_read(2'd3, v);
    chk(v[1] == 1'b1, "R9 busy head write sets error", v, 32'h2);
    wait_idle("R6 chain halts");
    chk(nb == 3, "R6 chain beat count", 32'(nb), 32'd3);
    chk(bd[0] == 32'hB000_0000 && bd[1] == 32'hB000_0001 && bd[2] == 32'hC000_0000,
        "R4 chain data under throttling", bd[2], 32'hC000_0000);
    chk(!bl[0] && !bl[1] && bl[2], "R5 no last without end-of-packet", {29'd0, bl[0], bl[1], bl[2]}, 32'd1);
    chk(mem[32 + 3] == 32'h8000_0008, "R3 mid-chain writeback no eoq", mem[35], 32'h8000_0008);
    chk(mem[40 + 3] == 32'h5000_0004, "R6 tail writeback eoq", mem[43], 32'h5000_0004);
    reg_read(2'd2, v);
    chk(irq && v == 32'h40, "R10 irq while cp lags", {31'd0, irq}, 32'd1);
    reg_write(2'd2, 32'hA0);
    chk(!irq, "R10 ack of tail", {31'd0, irq}, 32'd0);
    rdy_mode = 0;
  endtask

  task automatic t_owner_zero;
    put_desc(32'hC0, 32'h0, 32'h2C0, 32'd4, 32'hC000_0004);
    fill_buf(32'h2C0, 1, 32'hD000_0000);
    nb = 0;
    reg_write(2'd1, 32'hC0);
    wait_idle("R2 owner-clear stops");
    chk(nb == 0, "R2 no beats without ownership", 32'(nb), 32'd0);
    chk(mem[48 + 3] == 32'hC000_0004, "R2 no writeback without ownership", mem[51], 32'hC000_0004);
    put_desc(32'h60, 32'h0, 32'h2C0, 32'd0, 32'hE000_0000);
    reg_write(2'd1, 32'h60);
    wait_idle("R4 zero-length halts");
    chk(nb == 0, "R4 zero length sends nothing", 32'(nb), 32'd0);
    chk(mem[24 + 3] == 32'hD000_0000, "R4 zero length writeback", mem[27], 32'hD000_0000);
    reg_write(2'd2, 32'h60);
  endtask

  task automatic t_pending;
    logic [31:0] v;
    nb = 0;
    reg_write(2'd1, 32'h0);
    reg_read(2'd3, v);
    chk(v[0] == 1'b0, "R8 zero head keeps idle", v, 32'h0);
    reg_read(2'd1, v);
    chk(v == 32'h0, "R8 head reads zero when idle", v, 32'h0);
    put_desc(32'hE0, 32'h0, 32'h2C0, 32'd4, 32'hE000_0004);
    reg_write(2'd0, 32'd0);
    reg_write(2'd1, 32'hE0);
    repeat (20) @(negedge clk);
    chk(nb == 0, "R7 no stream while disabled", 32'(nb), 32'd0);
    reg_read(2'd1, v);
    chk(v == 32'hE0, "R8 head reads pending address", v, 32'hE0);
    reg_write(2'd0, 32'd1);
    wait_idle("R7 runs after enable");
    chk(nb == 1 && bd[0] == 32'hD000_0000 && bl[0], "R6 restart after halt", bd[0], 32'hD000_0000);
    reg_write(2'd2, 32'hE0);
  endtask

  task automatic t_teardown;
    logic [31:0] v;
    reg_write(2'd3, 32'd1);
    reg_read(2'd2, v);
    chk(v == 32'hE0, "R11 wrong channel ignored", v, 32'hE0);
    put_desc(32'h100, 32'h120, 32'h300, 32'd8, 32'hE000_0008);
    put_desc(32'h120, 32'h0, 32'h300, 32'd4, 32'hE000_0004);
    fill_buf(32'h300, 2, 32'hE000_0000);
    nb = 0; rdy_mode = 2;
    reg_write(2'd1, 32'h100);
    repeat (10) @(negedge clk);
    reg_write(2'd3, 32'd0);
    rdy_mode = 0;
    wait_idle("R11 teardown stops");
    chk(nb == 2, "R11 current descriptor finishes", 32'(nb), 32'd2);
    chk(mem[64 + 3] == 32'hC800_0008, "R11 teardown bit in descriptor", mem[67], 32'hC800_0008);
    chk(mem[72 + 3] == 32'hE000_0004, "R11 next descriptor untouched", mem[75], 32'hE000_0004);
    reg_read(2'd2, v);
    chk(v == MARK, "R11 marker in completion pointer", v, MARK);
    chk(!irq, "R11 irq low after teardown", {31'd0, irq}, 32'd0);
    reg_write(2'd2, 32'h40);
    reg_write(2'd3, 32'd0);
    reg_read(2'd2, v);
    chk(v == MARK, "R11 idle teardown marker", v, MARK);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    #200000000;
    errors++;
    $display("FAIL watchdog actual=%08h expected=%08h", 32'd1, 32'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_chain();
    t_owner_zero();
    t_pending();
    t_teardown();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule